// File: doc/BRIEF.md
# Not-Taken Branch Resolver

This block sits in the execute stage of an in-order pipeline whose fetch unit always assumes a conditional branch falls through. Each cycle it looks at the instruction currently in execute, decides whether that instruction is a branch whose condition holds, and if so steers fetch to the branch destination. It also tells the pipeline to clear the valid bit of the latch that feeds decode, so that the wrongly fetched instruction there becomes a bubble.

The destination is formed by adding the sign-extended offset to the PC that travelled down the pipeline with the branch. That PC is the fetch address before it was incremented. The block holds the fetch PC register. It steps by 4 every cycle, or loads the destination on a redirect.

Five free-running statistics counters are kept:
- instructions that reached execute as valid;
- branches;
- branches that fell through, which are correct guesses;
- branches that were taken, which are wrong guesses;
- cycles, where a wrong guess costs one extra count.

An invalid execute slot is a bubble. It never steers fetch and never moves any counter other than the cycle counter.

Top module: `nt_branch_unit`

## Requirements
- R1: While reset is held, every counter reads 0, fetch_pc reads RESET_PC (default 0), and redirect and flush_decode are low when ex_valid is low.
- R2: An instruction is a branch when ex_valid is 1 and ex_type equals 3. A branch with ex_funct3 = 3'b000 is taken when ex_op_a equals ex_op_b. A branch with ex_funct3 = 3'b001 is taken when the operands differ. In the same cycle as a taken branch, redirect and flush_decode are both 1.
- R3: In the same cycle as a taken branch, redirect_pc equals ex_pc + ex_offset. The offset is a two's-complement value, and the sum wraps modulo 2^XLEN.
- R4: A branch with any ex_funct3 other than 000 or 001 is never taken. A valid instruction with ex_type not equal to 3 never raises redirect or flush_decode.
- R5: Each valid branch adds 1 to cnt_branch at the next clock edge. That same edge also adds 1 to cnt_mispred if the branch was taken, or 1 to cnt_correct if it was not.
- R6: cnt_cycle grows by 1 at every clock edge after reset is released. On an edge that ends a taken-branch cycle it grows by 2 instead.
- R7: cnt_instr grows by 1 at each edge where ex_valid was 1, whatever the instruction type, and is unchanged otherwise.
- R8: When ex_valid is 0, redirect and flush_decode stay low, and cnt_instr, cnt_branch, cnt_correct and cnt_mispred keep their values.
- R9: After reset is released, fetch_pc becomes its previous value + 4 at each clock edge. At an edge that ends a taken-branch cycle it becomes that cycle's redirect_pc instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| ex_valid | input | 1 | Execute-stage latch holds a real instruction |
| ex_type | input | TYPE_W | Instruction type code; 3 marks a conditional branch |
| ex_pc | input | XLEN | Fetch-time PC of the execute-stage instruction |
| ex_offset | input | XLEN | Sign-extended branch offset |
| ex_funct3 | input | 3 | Branch condition selector |
| ex_op_a | input | XLEN | First compared operand |
| ex_op_b | input | XLEN | Second compared operand |
| redirect | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | XLEN | Branch destination |
| flush_decode | output | 1 | Clear the valid bit of the latch feeding decode |
| fetch_pc | output | XLEN | Current fetch address |
| cnt_instr | output | CNT_W | Valid instructions seen in execute |
| cnt_branch | output | CNT_W | Branches resolved |
| cnt_correct | output | CNT_W | Branches that fell through |
| cnt_mispred | output | CNT_W | Branches that were taken |
| cnt_cycle | output | CNT_W | Cycles, plus one per wrong guess |

## Verification
Three results are combinational: redirect, flush_decode and redirect_pc follow the execute inputs in the same cycle. The bench drives inputs on the falling edge and samples these outputs 1 ns later, before the next rising edge. fetch_pc and the five counters change at the rising edge that ends the stimulus cycle, so each scenario reads them at the following falling edge and compares them with values recorded at the falling edge where the stimulus was applied. Reset release passes through two synchronizer flops, so the bench waits several idle cycles before the first scenario.

// File: rtl/brr_pkg.sv
package brr_pkg;
  // Instruction type code that marks a conditional branch
  localparam int BR_TYPE_CODE = 3;

  // Branch condition selectors
  localparam logic [2:0] F3_EQ = 3'b000;
  localparam logic [2:0] F3_NE = 3'b001;

  // Counter slots in the statistics bank
  localparam int CNT_INSTR   = 0;
  localparam int CNT_BRANCH  = 1;
  localparam int CNT_CORRECT = 2;
  localparam int CNT_MISPRED = 3;
  localparam int CNT_CYCLE   = 4;
  localparam int NUM_CNT     = 5;

  // Width of a per-cycle counter step (0, 1 or 2)
  localparam int STEP_W = 2;

  function automatic logic cond_holds(input logic [2:0] f3, input logic same);
    case (f3)
      F3_EQ:   cond_holds = same;
      F3_NE:   cond_holds = !same;
      default: cond_holds = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/brr_rst_sync.sv
module brr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/brr_cond_eval.sv
module brr_cond_eval
  import brr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int TYPE_W = 2
) (
  input  logic              valid,
  input  logic [TYPE_W-1:0] itype,
  input  logic [2:0]        funct3,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  output logic              is_branch,
  output logic              taken
);
  logic same;

  always_comb begin
    same      = (op_a == op_b);
    is_branch = valid && (itype == TYPE_W'(BR_TYPE_CODE));
    taken     = is_branch && cond_holds(funct3, same);
  end
endmodule

// File: rtl/brr_fetch_pc.sv
module brr_fetch_pc #(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);
  localparam logic [XLEN-1:0] PC_INIT = XLEN'(RESET_PC);

  logic [XLEN-1:0] pc_q, pc_d;

  always_comb begin
    if (load) pc_d = target;
    else      pc_d = pc_q + PC_STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= PC_INIT;
    else        pc_q <= pc_d;
  end

  assign pc = pc_q;

  // R9: sequential step when no redirect
  a_r9_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (pc_q == $past(pc_q) + PC_STEP));
  // R9: redirect loads the destination
  a_r9_redirect_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pc_q == $past(target)));
endmodule

// File: rtl/brr_counter_bank.sv
module brr_counter_bank
  import brr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_CNT-1:0][STEP_W-1:0]  step,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   cnt
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [CNT_W-1:0] q, d;
    logic             en;

    always_comb begin
      en = (step[i] != '0);
      d  = q + CNT_W'(step[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign cnt[i] = q;
  end

  // R5: every branch lands in exactly one of correct / mispredicted
  a_r5_split: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cnt[CNT_BRANCH] - $past(cnt[CNT_BRANCH])) ==
              (cnt[CNT_CORRECT] - $past(cnt[CNT_CORRECT])) +
              (cnt[CNT_MISPRED] - $past(cnt[CNT_MISPRED]))));
  // R6: cycle counter moves by one or two per edge
  a_r6_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((cnt[CNT_CYCLE] - $past(cnt[CNT_CYCLE])) == CNT_W'(1)) ||
              ((cnt[CNT_CYCLE] - $past(cnt[CNT_CYCLE])) == CNT_W'(2))));
  // R7: instruction counter moves by at most one per edge
  a_r7_instr_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cnt[CNT_INSTR] - $past(cnt[CNT_INSTR])) <= CNT_W'(1)));
endmodule

// File: rtl/nt_branch_unit.sv
module nt_branch_unit
  import brr_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          TYPE_W   = 2,
  parameter int          CNT_W    = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_valid,
  input  logic [TYPE_W-1:0] ex_type,
  input  logic [XLEN-1:0]   ex_pc,
  input  logic [XLEN-1:0]   ex_offset,
  input  logic [2:0]        ex_funct3,
  input  logic [XLEN-1:0]   ex_op_a,
  input  logic [XLEN-1:0]   ex_op_b,
  output logic              redirect,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              flush_decode,
  output logic [XLEN-1:0]   fetch_pc,
  output logic [CNT_W-1:0]  cnt_instr,
  output logic [CNT_W-1:0]  cnt_branch,
  output logic [CNT_W-1:0]  cnt_correct,
  output logic [CNT_W-1:0]  cnt_mispred,
  output logic [CNT_W-1:0]  cnt_cycle
);
  logic rst_sync_n;
  logic is_branch, taken;
  logic [NUM_CNT-1:0][STEP_W-1:0] step;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt;

  brr_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  brr_cond_eval #(.XLEN(XLEN), .TYPE_W(TYPE_W)) u_cond (
    .valid     (ex_valid),
    .itype     (ex_type),
    .funct3    (ex_funct3),
    .op_a      (ex_op_a),
    .op_b      (ex_op_b),
    .is_branch (is_branch),
    .taken     (taken)
  );

  always_comb begin
    redirect     = taken;
    flush_decode = taken;
    redirect_pc  = ex_pc + ex_offset;
  end

  brr_fetch_pc #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (taken),
    .target (redirect_pc),
    .pc     (fetch_pc)
  );

  always_comb begin
    step              = '0;
    step[CNT_INSTR]   = STEP_W'(ex_valid);
    step[CNT_BRANCH]  = STEP_W'(is_branch);
    step[CNT_CORRECT] = STEP_W'(is_branch && !taken);
    step[CNT_MISPRED] = STEP_W'(taken);
    step[CNT_CYCLE]   = taken ? STEP_W'(2) : STEP_W'(1);
  end

  brr_counter_bank #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .step  (step),
    .cnt   (cnt)
  );

  assign cnt_instr   = cnt[CNT_INSTR];
  assign cnt_branch  = cnt[CNT_BRANCH];
  assign cnt_correct = cnt[CNT_CORRECT];
  assign cnt_mispred = cnt[CNT_MISPRED];
  assign cnt_cycle   = cnt[CNT_CYCLE];

  // R8: a bubble never steers fetch
  a_r8_bubble_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ex_valid |-> (!redirect && !flush_decode));
  // R4: non-branch types never steer fetch
  a_r4_nonbranch_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ex_valid && (ex_type != TYPE_W'(BR_TYPE_CODE))) |-> !redirect);
  // R8: bubble leaves instruction and branch counts alone
  a_r8_bubble_counts: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ex_valid |=> ($stable(cnt_instr) && $stable(cnt_branch)));
  // R5: a taken branch bumps the misprediction count
  a_r5_mispred_bump: assert property (@(posedge clk) disable iff (!rst_sync_n)
    redirect |=> (cnt_mispred == $past(cnt_mispred) + CNT_W'(1)));
endmodule

// File: tb/sim_nt_branch_unit.sv
`timescale 1ns/1ps
module sim_nt_branch_unit;
  localparam int XLEN = 32;
  localparam int TW   = 2;
  localparam int CW   = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic ex_valid;
  logic [TW-1:0] ex_type;
  logic [XLEN-1:0] ex_pc, ex_offset, ex_op_a, ex_op_b;
  logic [2:0] ex_funct3;
  logic redirect, flush_decode;
  logic [XLEN-1:0] redirect_pc, fetch_pc;
  logic [CW-1:0] cnt_instr, cnt_branch, cnt_correct, cnt_mispred, cnt_cycle;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model of the statistics counts, built from the requirements
  logic [CW-1:0] m_instr = '0, m_branch = '0, m_correct = '0, m_mispred = '0;

  always #2.5 clk = ~clk;

  nt_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_type(ex_type),
    .ex_pc(ex_pc), .ex_offset(ex_offset), .ex_funct3(ex_funct3),
    .ex_op_a(ex_op_a), .ex_op_b(ex_op_b), .redirect(redirect),
    .redirect_pc(redirect_pc), .flush_decode(flush_decode), .fetch_pc(fetch_pc),
    .cnt_instr(cnt_instr), .cnt_branch(cnt_branch), .cnt_correct(cnt_correct),
    .cnt_mispred(cnt_mispred), .cnt_cycle(cnt_cycle)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_idle();
    ex_valid = 1'b0; ex_type = '0; ex_pc = '0; ex_offset = '0;
    ex_funct3 = 3'b000; ex_op_a = '0; ex_op_b = '0;
  endtask

  // Apply one execute-stage instruction for one cycle and check every result.
  task automatic run_one(input string tag, input logic v, input logic [TW-1:0] ty,
                         input logic [XLEN-1:0] pc, input logic [XLEN-1:0] off,
                         input logic [2:0] f3, input logic [XLEN-1:0] a,
                         input logic [XLEN-1:0] b);
    logic is_br, tk;
    logic [XLEN-1:0] pc0, tgt;
    logic [CW-1:0] cyc0;
    @(negedge clk);
    pc0 = fetch_pc; cyc0 = cnt_cycle;
    ex_valid = v; ex_type = ty; ex_pc = pc; ex_offset = off;
    ex_funct3 = f3; ex_op_a = a; ex_op_b = b;
    is_br = v && (ty == TW'(3));
    tk = is_br && (((f3 == 3'b000) && (a == b)) || ((f3 == 3'b001) && (a != b)));
    tgt = pc + off;
    #1;
    chk({tag, " R2 redirect"}, {63'd0, redirect}, {63'd0, tk});
    chk({tag, " R2 flush_decode"}, {63'd0, flush_decode}, {63'd0, tk});
    if (tk) chk({tag, " R3 redirect_pc"}, 64'(redirect_pc), 64'(tgt));
    if (v) m_instr++;
    if (is_br) begin
      m_branch++;
      if (tk) m_mispred++; else m_correct++;
    end
    @(negedge clk);
    set_idle();
    chk({tag, " R9 fetch_pc"}, 64'(fetch_pc), tk ? 64'(tgt) : 64'(pc0 + 32'd4));
    chk({tag, " R6 cnt_cycle"}, 64'(cnt_cycle), 64'(cyc0 + (tk ? 32'd2 : 32'd1)));
    chk({tag, " R7 cnt_instr"}, 64'(cnt_instr), 64'(m_instr));
    chk({tag, " R5 cnt_branch"}, 64'(cnt_branch), 64'(m_branch));
    chk({tag, " R5 cnt_correct"}, 64'(cnt_correct), 64'(m_correct));
    chk({tag, " R5 cnt_mispred"}, 64'(cnt_mispred), 64'(m_mispred));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; set_idle();
    repeat (3) @(negedge clk);
    chk("R1 fetch_pc", 64'(fetch_pc), 64'h0);
    chk("R1 cnt_cycle", 64'(cnt_cycle), 64'h0);
    chk("R1 cnt_instr", 64'(cnt_instr), 64'h0);
    chk("R1 cnt_branch", 64'(cnt_branch), 64'h0);
    chk("R1 cnt_mispred", 64'(cnt_mispred), 64'h0);
    chk("R1 redirect", {63'd0, redirect}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_beq();
    run_one("beq taken", 1'b1, 2'd3, 32'h100, 32'h40, 3'b000, 32'd7, 32'd7);
    run_one("beq fall", 1'b1, 2'd3, 32'h104, 32'h40, 3'b000, 32'd7, 32'd8);
  endtask

  task automatic t_bne();
    run_one("bne taken", 1'b1, 2'd3, 32'h200, 32'h10, 3'b001, 32'd1, 32'd2);
    run_one("bne fall", 1'b1, 2'd3, 32'h204, 32'h10, 3'b001, 32'hA5, 32'hA5);
  endtask

  task automatic t_r4_other_codes();
    run_one("R4 funct3=100", 1'b1, 2'd3, 32'h300, 32'h20, 3'b100, 32'd5, 32'd5);
    run_one("R4 funct3=111", 1'b1, 2'd3, 32'h304, 32'h20, 3'b111, 32'd5, 32'd6);
    run_one("R4 type0", 1'b1, 2'd0, 32'h308, 32'h20, 3'b000, 32'd9, 32'd9);
    run_one("R4 type2", 1'b1, 2'd2, 32'h30C, 32'h20, 3'b001, 32'd1, 32'd9);
  endtask

  task automatic t_r8_bubble();
    run_one("R8 bubble beq", 1'b0, 2'd3, 32'h400, 32'h80, 3'b000, 32'd3, 32'd3);
    run_one("R8 bubble bne", 1'b0, 2'd3, 32'h404, 32'h80, 3'b001, 32'd3, 32'd4);
  endtask

  task automatic t_r3_offsets();
    run_one("R3 negative offset", 1'b1, 2'd3, 32'h100, 32'hFFFF_FFF8, 3'b000, 32'd0, 32'd0);
    run_one("R3 wrap", 1'b1, 2'd3, 32'hFFFF_FFFC, 32'h8, 3'b001, 32'd0, 32'd1);
  endtask

  task automatic t_back_to_back();
    run_one("b2b first", 1'b1, 2'd3, 32'h500, 32'h100, 3'b000, 32'd4, 32'd4);
    run_one("b2b second", 1'b1, 2'd3, 32'h600, 32'h200, 3'b001, 32'd4, 32'd5);
  endtask

  initial begin
    t_reset();
    t_beq();
    t_bne();
    t_r4_other_codes();
    t_r8_bubble();
    t_r3_offsets();
    t_back_to_back();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule